// File: doc/BRIEF.md
# Transmit Status and Interrupt Register

This block is the transmit status byte of a network data link controller, as the host sees it. The transmit engine sends it one-cycle event pulses: end of packet, own frame received back, carrier lost, jabber, collision, sixteenth collision and bus write error. The block latches each event into a sticky flag. Bit 6 of the same byte is not a flag. It shows the carrier-sense input live. The host reads the byte through a small register port and clears the flags it has handled by writing ones to them. A second byte on the same port holds the interrupt enables, and the interrupt line is raised while any enabled flag is set.

Two of the flags report on a single packet, so a packet-start strobe clears them automatically. The end-of-packet event counts as "transmit done" only when the transmit queue reports empty at that moment. In dual-bank mode a qualified done event also produces a one-cycle pulse that starts the second bank. In single-bank mode the block raises a level that tells the host it may load the next frame. No data streams through this block, so it has no valid/ready handshakes. Every pin is a plain control or status signal.

Top module: `txs_status_reg`

## Requirements
- R1: After reset every sticky flag and every enable bit is 0, irq is 0 and bank_go is 0.
- R2: With reg_sel=0, reg_rdata returns the status byte in this layout: bit 7 done, bit 6 carrier, bit 5 own-frame-received, bit 4 carrier-lost, bit 3 jabber, bit 2 collision, bit 1 sixteen-collisions, bit 0 bus write error. With reg_sel=1 it returns the enable byte. reg_rdata is combinational from the stored state.
- R3: A status write (reg_wr=1, reg_sel=0) clears every flag whose bit in reg_wdata is 1. Flags whose bit is 0 keep their value. The change shows one cycle later.
- R4: An event pulse on ev_self_rx, ev_carrier_lost, ev_jabber, ev_collision, ev_coll16 or ev_bus_wr_err sets its flag at the next clock edge. The flag stays set until it is cleared.
- R5: The done flag (bit 7) sets only when pkt_end and txq_empty are both 1 in the same cycle. A pkt_end while txq_empty=0 leaves the flag unchanged.
- R6: Status bit 6 always equals carrier_sense. Status writes have no effect on it, and it never drives irq.
- R7: pkt_start clears flags 5 and 4 at the next edge. It leaves every other flag unchanged.
- R8: When a set event and a clear hit the same flag in the same cycle, the flag ends up set. This holds for a host write clear and for a pkt_start clear.
- R9: irq is 1 exactly when some flag among bits 7, 3, 2, 1, 0 is set and its enable bit is also 1. Bits 6, 5 and 4 never assert irq, whatever their enable bits hold.
- R10: With dual_bank=1, bank_go pulses for one cycle, one cycle after a qualified done event. With dual_bank=0, bank_go stays 0. host_load_ok equals the done flag AND NOT dual_bank.
- R11: An enable write (reg_wr=1, reg_sel=1) loads reg_wdata into the enable byte and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_end | input | 1 | Pulse: a packet finished sending |
| txq_empty | input | 1 | Level: no further packet waits in the transmit buffer |
| ev_self_rx | input | 1 | Pulse: own frame seen received normally |
| ev_carrier_lost | input | 1 | Pulse: carrier dropped during transmission |
| ev_jabber | input | 1 | Pulse: jabber condition |
| ev_collision | input | 1 | Pulse: collision seen |
| ev_coll16 | input | 1 | Pulse: sixteenth collision, packet abandoned |
| ev_bus_wr_err | input | 1 | Pulse: host bus write error |
| pkt_start | input | 1 | Pulse: transmission of a packet begins |
| carrier_sense | input | 1 | Level: carrier present on the medium |
| dual_bank | input | 1 | 1 selects dual-bank mode, 0 selects single-bank mode |
| reg_sel | input | 1 | 0 selects the status byte, 1 selects the enable byte |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected byte |
| irq | output | 1 | Interrupt request |
| bank_go | output | 1 | Pulse that starts the second bank (dual mode) |
| host_load_ok | output | 1 | Host may load the next frame (single mode) |

## Verification
A flag can be set and cleared in the same cycle in two ways. A host write-one-to-clear can land in the cycle an event arrives, and a packet-start strobe can land in the cycle an own-frame-received or carrier-lost event arrives. The bench first forces each pairing directly on every flag and expects the flag to read back set. A long pseudo-random run then drives events, clear masks and packet starts at the same time, and a cycle-level model built from the requirements predicts every status byte, the enable byte and irq.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int unsigned TXS_W = 8;

  localparam int unsigned B_DONE  = 7;
  localparam int unsigned B_CARR  = 6;
  localparam int unsigned B_SELF  = 5;
  localparam int unsigned B_SHORT = 4;
  localparam int unsigned B_JAB   = 3;
  localparam int unsigned B_COL   = 2;
  localparam int unsigned B_COL16 = 1;
  localparam int unsigned B_BUSWR = 0;

  typedef logic [TXS_W-1:0] txs_byte_t;

  // bits that hold sticky state
  localparam txs_byte_t STORE_MASK   = 8'hBF;
  // bits cleared by packet start
  localparam txs_byte_t AUTOCLR_MASK = 8'h30;
  // bits allowed to raise the interrupt
  localparam txs_byte_t IRQ_MASK     = 8'h8F;

  typedef enum logic {SEL_STATUS = 1'b0, SEL_ENABLE = 1'b1} txs_sel_e;
endpackage

// File: rtl/txs_flag_bank.sv
module txs_flag_bank #(
  parameter int unsigned W          = 8,
  parameter logic [W-1:0] STORE     = '1,
  parameter logic [W-1:0] AUTOCLR   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         auto_clr,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (STORE[i]) begin : g_store
      logic q;
      logic kill;
      always_comb begin
        kill = clr_vec[i];
        if (AUTOCLR[i] && auto_clr) kill = 1'b1;
      end
      always_ff @(posedge clk) begin
        if (!rst_n)          q <= 1'b0;
        else if (set_vec[i]) q <= 1'b1;
        else if (kill)       q <= 1'b0;
      end
      assign flags[i] = q;

      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> flags[i]);
      p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_vec[i] && !clr_vec[i] && !(auto_clr && AUTOCLR[i])) |=> $stable(flags[i]));
      if (AUTOCLR[i]) begin : g_ac
        p_autoclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
          (auto_clr && !set_vec[i]) |=> !flags[i]);
      end
    end else begin : g_none
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/txs_irq_unit.sv
module txs_irq_unit #(
  parameter int unsigned W        = 8,
  parameter logic [W-1:0] SRC_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic [W-1:0] en_wdata,
  input  logic [W-1:0] flags,
  output logic [W-1:0] en_q,
  output logic         irq
);
  logic [W-1:0] hits;

  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  always_comb begin
    hits = flags & en_q & SRC_MASK;
    irq  = |hits;
  end

  p_en_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (en_q == $past(en_wdata)));
  p_en_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q));
endmodule

// File: rtl/txs_bank_ctl.sv
module txs_bank_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic dual,
  input  logic done_flag,
  output logic bank_go,
  output logic host_load_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) bank_go <= 1'b0;
    else        bank_go <= done_evt & dual;
  end

  assign host_load_ok = done_flag & ~dual;

  p_go_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_go |-> ($past(dual) && $past(done_evt)));
  p_go_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bank_go |-> done_flag);
endmodule

// File: rtl/txs_status_reg.sv
module txs_status_reg
  import txs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pkt_end,
  input  logic       txq_empty,
  input  logic       ev_self_rx,
  input  logic       ev_carrier_lost,
  input  logic       ev_jabber,
  input  logic       ev_collision,
  input  logic       ev_coll16,
  input  logic       ev_bus_wr_err,
  input  logic       pkt_start,
  input  logic       carrier_sense,
  input  logic       dual_bank,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       bank_go,
  output logic       host_load_ok
);
  txs_byte_t set_vec, clr_vec, flags, en_q, status;
  logic      done_evt, stat_wr, en_wr;

  assign done_evt = pkt_end & txq_empty;
  assign stat_wr  = reg_wr && (txs_sel_e'(reg_sel) == SEL_STATUS);
  assign en_wr    = reg_wr && (txs_sel_e'(reg_sel) == SEL_ENABLE);

  always_comb begin
    set_vec          = '0;
    set_vec[B_DONE]  = done_evt;
    set_vec[B_SELF]  = ev_self_rx;
    set_vec[B_SHORT] = ev_carrier_lost;
    set_vec[B_JAB]   = ev_jabber;
    set_vec[B_COL]   = ev_collision;
    set_vec[B_COL16] = ev_coll16;
    set_vec[B_BUSWR] = ev_bus_wr_err;
    clr_vec          = stat_wr ? (reg_wdata & STORE_MASK) : '0;
  end

  txs_flag_bank #(.W(TXS_W), .STORE(STORE_MASK), .AUTOCLR(AUTOCLR_MASK)) u_flags (
    .clk, .rst_n, .set_vec, .clr_vec, .auto_clr(pkt_start), .flags
  );

  txs_irq_unit #(.W(TXS_W), .SRC_MASK(IRQ_MASK)) u_irq (
    .clk, .rst_n, .en_wr, .en_wdata(reg_wdata), .flags, .en_q, .irq
  );

  txs_bank_ctl u_bank (
    .clk, .rst_n, .done_evt, .dual(dual_bank), .done_flag(flags[B_DONE]),
    .bank_go, .host_load_ok
  );

  always_comb begin
    status         = flags;
    status[B_CARR] = carrier_sense;
    reg_rdata      = (txs_sel_e'(reg_sel) == SEL_ENABLE) ? en_q : status;
  end

  p_carrier_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 1'b0) |-> (reg_rdata[B_CARR] == carrier_sense));
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && ($past(set_vec) == '0)) |-> !$rose(irq));
  p_done_qual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end && !txq_empty && !flags[B_DONE]) |=> !flags[B_DONE]);
  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!irq && !bank_go && (en_q == '0)));
endmodule

// File: tb/txs_status_reg_test.sv
module txs_status_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pkt_end = 0, txq_empty = 0, ev_self_rx = 0, ev_carrier_lost = 0;
  logic ev_jabber = 0, ev_collision = 0, ev_coll16 = 0, ev_bus_wr_err = 0;
  logic pkt_start = 0, carrier_sense = 0, dual_bank = 0, reg_sel = 0, reg_wr = 0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, bank_go, host_load_ok;

  int n_run = 0, n_fail = 0;
  logic [7:0] eq = '0, een = '0;
  logic ego = 1'b0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  txs_status_reg uut (.*);

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic observe();
    reg_sel = 1'b0; #0.5;
    chk("status", reg_rdata, eq | {1'b0, carrier_sense, 6'b0});
    reg_sel = 1'b1; #0.5;
    chk("enable", reg_rdata, een);
    chk("irq", {7'b0, irq}, {7'b0, |(eq & een & 8'h8F)});
    chk("bank_go", {7'b0, bank_go}, {7'b0, ego});
    chk("host_load_ok", {7'b0, host_load_ok}, {7'b0, eq[7] & ~dual_bank});
  endtask

  // ev bit mapping: 7 pkt_end, 5 self_rx, 4 carrier_lost, 3 jabber, 2 collision, 1 coll16, 0 bus_wr_err
  task automatic step(logic [7:0] ev, logic qe, logic st, logic wr, logic sel, logic [7:0] wd);
    logic [7:0] setv, clrv;
    pkt_end = ev[7]; txq_empty = qe; ev_self_rx = ev[5]; ev_carrier_lost = ev[4];
    ev_jabber = ev[3]; ev_collision = ev[2]; ev_coll16 = ev[1]; ev_bus_wr_err = ev[0];
    pkt_start = st; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk);
    setv = {ev[7] & qe, 1'b0, ev[5:0]};
    clrv = (wr && !sel) ? (wd & 8'hBF) : 8'h00;
    eq   = (setv | (eq & ~clrv & ~(st ? 8'h30 : 8'h00))) & 8'hBF;
    if (wr && sel) een = wd;
    ego  = ev[7] & qe & dual_bank;
    @(negedge clk);
    {pkt_end, ev_self_rx, ev_carrier_lost, ev_jabber, ev_collision, ev_coll16, ev_bus_wr_err} = '0;
    pkt_start = 0; reg_wr = 0; reg_wdata = '0;
    observe();
  endtask

  task automatic idle(); step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00); endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1"; observe();
    rst_n = 1'b1;
    idle();

    // R2 R4: each event sets its own flag and reads back in place
    tag = "R2 R4";
    for (int b = 0; b < 8; b++) begin
      if (b == 6) continue;
      step(8'h01 << b, 1'b1, 0, 0, 0, 8'h00);
      idle();
      step(8'h00, 0, 0, 1, 0, 8'hFF);
    end

    // R3: write-one-to-clear per bit, zero bits untouched
    tag = "R3";
    for (int b = 0; b < 8; b++) begin
      step(8'hBF, 1'b1, 0, 0, 0, 8'h00);
      step(8'h00, 0, 0, 1, 0, 8'h01 << b);
      step(8'h00, 0, 0, 1, 0, 8'h00);
    end
    step(8'h00, 0, 0, 1, 0, 8'hFF);

    // R5: done needs queue empty
    tag = "R5";
    step(8'h80, 1'b0, 0, 0, 0, 8'h00);
    step(8'h80, 1'b1, 0, 0, 0, 8'h00);
    step(8'h00, 0, 0, 1, 0, 8'h80);

    // R6: carrier live, write ignored
    tag = "R6";
    carrier_sense = 1'b1; idle();
    step(8'h00, 0, 0, 1, 0, 8'h40);
    step(8'h00, 0, 0, 1, 1, 8'h70);
    carrier_sense = 1'b0; idle();
    step(8'h00, 0, 0, 1, 1, 8'h00);

    // R7: packet start clears bits 5,4 only
    tag = "R7";
    step(8'hBF, 1'b1, 0, 0, 0, 8'h00);
    step(8'h00, 0, 1, 0, 0, 8'h00);
    step(8'h00, 0, 0, 1, 0, 8'hFF);

    // R8: set beats clear in the same cycle
    tag = "R8";
    for (int b = 0; b < 8; b++) begin
      if (b == 6) continue;
      step(8'h01 << b, 1'b1, 0, 1, 0, 8'h01 << b);
      step(8'h01 << b, 1'b1, 1, 0, 0, 8'h00);
      step(8'h00, 0, 0, 1, 0, 8'hFF);
    end

    // R9 R11: every enable pattern against all flags set and against single flags
    tag = "R9 R11";
    step(8'hBF, 1'b1, 0, 0, 0, 8'h00);
    for (int e = 0; e < 256; e++) step(8'h00, 0, 0, 1, 1, 8'(e));
    step(8'h00, 0, 0, 1, 0, 8'hFF);
    step(8'h00, 0, 0, 1, 1, 8'h70);
    step(8'h30, 0, 0, 0, 0, 8'h00);
    carrier_sense = 1'b1; idle(); carrier_sense = 1'b0;
    step(8'h00, 0, 0, 1, 0, 8'hFF);

    // R10: bank modes
    tag = "R10";
    dual_bank = 1'b1;
    step(8'h80, 1'b1, 0, 0, 0, 8'h00);
    idle();
    step(8'h80, 1'b0, 0, 0, 0, 8'h00);
    dual_bank = 1'b0;
    step(8'h80, 1'b1, 0, 0, 0, 8'h00);
    step(8'h00, 0, 0, 1, 0, 8'h80);

    // random sweep with coincidences
    tag = "R3 R4 R7 R8 R9";
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      carrier_sense = lf[3];
      dual_bank = lf[9];
      step(lf[7:0] & {lf[15:12], lf[11:8]}, lf[10], lf[11], lf[12] & lf[1], lf[13] & lf[2], {lf[4:0], lf[15:13]});
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule